// File: doc/BRIEF.md
# Thermal Sensor Code Converter

This block turns the raw digital code of an on-die temperature sensor into a signed temperature in milli-degrees Celsius, and turns a temperature back into a sensor code. Each sensor keeps a slope and an offset in a small coefficient store inside the block. The conversions are linear and use those coefficients. A fixed scale factor keeps the fractional part of the slope in integer arithmetic.

The coefficients come from a calibration request. A two-point request gives the codes read at two fixed reference temperatures, 30 °C and 120 °C. The slope then follows from their difference and the offset from the lower point. A one-point request gives only the 30 °C code. It installs a default slope and derives the offset from that code.

Requests use a simple handshake: the caller raises `req_valid` while the block is idle. The block then keeps `busy` high until it raises `done` for one cycle with the result. All divisions run on one shared sequential divider that produces one quotient bit per cycle.

Top module: `tc_conv`

## Requirements
- R1: After reset, `busy` and `done` are low. Every sensor holds slope DEF_SLOPE (3200) and offset 0. A code-to-temperature request on an uncalibrated sensor therefore yields round(code×3200/3200)×1000.
- R2: `req_op` encodes the operation: 0 is code-to-temperature, 1 is temperature-to-code, 2 is two-point calibration and 3 is one-point calibration. A request is taken only on a clock edge where `req_valid` is high and `busy` is low. From the next cycle, `busy` stays high until the edge on which `done` rises. `done` is high for exactly one cycle. A request raised while `busy` is high is ignored.
- R3: Two-point calibration uses `req_a[9:0]` as code1 and `req_b[9:0]` as code2. It stores slope = ((code2−code1)×SCALE)/90, with the division truncated toward zero, and offset = code1×SCALE − 30×slope. `resp_data` returns the new slope.
- R4: One-point calibration stores slope = DEF_SLOPE and offset = code1×SCALE − 30×DEF_SLOPE. `resp_data` returns DEF_SLOPE.
- R5: Code-to-temperature first forms num = code×SCALE − offset, where the code is `req_a[9:0]`. It adds half the slope when num is positive, subtracts it when num is negative, and leaves a zero num unchanged. It then divides by the slope with truncation toward zero and returns the quotient ×1000. Ties therefore round away from zero.
- R6: Temperature-to-code takes `req_a` in milli-degrees and divides it by 1000, truncating toward zero. It returns (degC×slope + offset)/SCALE, also truncated toward zero.
- R7: The temperature-to-code result is clamped to the range CODE_MIN..CODE_MAX (0..1023).
- R8: A code-to-temperature request on a sensor whose slope is zero returns 0 with `resp_err` high. Every other completed request has `resp_err` low.
- R9: Calibration writes only the coefficients of the sensor selected by `req_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | Operation select (see R2) |
| req_idx | input | 2 | Sensor index |
| req_a | input | 32 | Code in bits 9:0 (ops 0, 2, 3) or signed milli-degrees (op 1) |
| req_b | input | 32 | Second calibration code in bits 9:0 (op 2) |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result strobe |
| resp_data | output | 32 | Signed result |
| resp_err | output | 1 | Zero-slope error |

## Verification
The bench aims codes at results that fall exactly on a half degree, on both sides of zero. A design that rounds half toward zero, or rounds half up without regard to sign, returns ±0 instead of ±1000 for these codes. It also feeds negative milli-degree inputs that are not whole degrees. A design that floors instead of truncating then moves the code by several counts. Temperatures far outside the sensor range check the clamp, which an unclamped design would let wrap or go negative. A two-point calibration with equal codes produces a zero slope, and the bench expects a zero result with the error flag instead of the all-ones quotient a bare divider would give.

// File: rtl/tc_pkg.sv
// Shared types of the thermal code converter.
// Assumes a 2-bit operation field on the request port.
package tc_pkg;
    typedef enum logic [1:0] {
        OP_C2T  = 2'd0,
        OP_T2C  = 2'd1,
        OP_CAL2 = 2'd2,
        OP_CAL1 = 2'd3
    } tc_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_WAIT = 2'd2,
        ST_FIN  = 2'd3
    } tc_state_e;
endpackage

// File: rtl/tc_sdiv.sv
// Signed restoring divider, one quotient bit per cycle.
// Quotient truncates toward zero. Takes W cycles after start; done pulses once.
// Assumes start is only raised while no division runs. A zero divisor
// gives an undefined quotient that the caller must mask.
module tc_sdiv #(
    parameter int W = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic signed [W-1:0] dvd,
    input  logic signed [W-1:0] dvs,
    output logic signed [W-1:0] quo,
    output logic                done
);
    localparam int CNTW = $clog2(W + 1);

    logic [W:0]      rem_q;
    logic [W-1:0]    qr_q;
    logic [W-1:0]    dv_q;
    logic [CNTW-1:0] cnt_q;
    logic            neg_q;
    logic            run_q;
    logic [W:0]      trial;
    logic            fits;

    // Trial subtraction of the shifted remainder
    always_comb begin
        trial = {rem_q[W-1:0], qr_q[W-1]};
        fits  = (trial >= {1'b0, dv_q});
    end

    // Operand capture and iteration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            qr_q  <= '0;
            dv_q  <= '0;
            cnt_q <= '0;
            neg_q <= 1'b0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                qr_q  <= dvd[W-1] ? -dvd : dvd;
                dv_q  <= dvs[W-1] ? -dvs : dvs;
                neg_q <= dvd[W-1] ^ dvs[W-1];
                rem_q <= '0;
                cnt_q <= CNTW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= fits ? (trial - {1'b0, dv_q}) : trial;
                qr_q  <= {qr_q[W-2:0], fits};
                cnt_q <= cnt_q - CNTW'(1);
                if (cnt_q == CNTW'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    assign quo = neg_q ? -$signed(qr_q) : $signed(qr_q);
endmodule

// File: rtl/tc_coef_rf.sv
// Per-sensor slope and offset store with one write and one read port.
// Resets every entry to the default slope and a zero offset. Read is combinational.
module tc_coef_rf #(
    parameter int NSENS     = 4,
    parameter int DW        = 32,
    parameter int DEF_SLOPE = 3200,
    localparam int IDXW     = (NSENS > 1) ? $clog2(NSENS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [IDXW-1:0]      idx,
    input  logic signed [DW-1:0] wr_slope,
    input  logic signed [DW-1:0] wr_off,
    output logic signed [DW-1:0] rd_slope,
    output logic signed [DW-1:0] rd_off
);
    logic signed [DW-1:0] slope_q [NSENS];
    logic signed [DW-1:0] off_q   [NSENS];

    for (genvar i = 0; i < NSENS; i++) begin : g_ent
        // One entry: written only when its index is selected
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slope_q[i] <= DW'(DEF_SLOPE);
                off_q[i]   <= '0;
            end else if (we && (idx == IDXW'(i))) begin
                slope_q[i] <= wr_slope;
                off_q[i]   <= wr_off;
            end
        end
    end

    assign rd_slope = slope_q[idx];
    assign rd_off   = off_q[idx];
endmodule

// File: rtl/tc_conv.sv
// Thermal sensor code converter top level.
// Sequences code-to-temperature, temperature-to-code and calibration over one
// shared divider. Assumes XW is wide enough for degC*slope products.
// Requests are taken only when idle. Result is held until the next done.
module tc_conv
    import tc_pkg::*;
#(
    parameter int NSENS     = 4,
    parameter int CODE_W    = 10,
    parameter int DW        = 32,
    parameter int XW        = 48,
    parameter int SCALE     = 3200,
    parameter int DEF_SLOPE = 3200,
    parameter int CAL_LO    = 30,
    parameter int CAL_HI    = 120,
    parameter int CODE_MIN  = 0,
    parameter int CODE_MAX  = 1023,
    parameter int MILLI     = 1000,
    localparam int IDXW     = (NSENS > 1) ? $clog2(NSENS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [1:0]           req_op,
    input  logic [IDXW-1:0]      req_idx,
    input  logic signed [DW-1:0] req_a,
    input  logic signed [DW-1:0] req_b,
    output logic                 busy,
    output logic                 done,
    output logic signed [DW-1:0] resp_data,
    output logic                 resp_err
);
    localparam logic signed [XW-1:0] SCALE_X = XW'(SCALE);
    localparam logic signed [XW-1:0] MILLI_X = XW'(MILLI);
    localparam logic signed [XW-1:0] CALLO_X = XW'(CAL_LO);
    localparam logic signed [XW-1:0] SPAN_X  = XW'(CAL_HI - CAL_LO);
    localparam logic signed [XW-1:0] CMIN_X  = XW'(CODE_MIN);
    localparam logic signed [XW-1:0] CMAX_X  = XW'(CODE_MAX);

    tc_state_e            state_q;
    tc_op_e               op_q;
    logic [IDXW-1:0]      idx_q;
    logic signed [DW-1:0] a_q;
    logic [CODE_W-1:0]    b_q;
    logic                 phase_q;
    logic                 zs_q;
    logic signed [XW-1:0] deg_q;
    logic signed [XW-1:0] quo_q;

    logic signed [DW-1:0] rd_slope, rd_off, wr_slope, wr_off;
    logic signed [XW-1:0] slope_x, off_x, a_x, code_a, code_b;
    logic signed [XW-1:0] num, half, num_r, dvd, dvs, div_q, new_slope_x, t2c_x;
    logic signed [DW-1:0] c2t_d, fin_data;
    logic                 div_start, div_done, rf_we, zero_slope;

    assign slope_x = rd_slope;
    assign off_x   = rd_off;
    assign a_x     = a_q;
    assign code_a  = {{(XW - CODE_W){1'b0}}, a_q[CODE_W-1:0]};
    assign code_b  = {{(XW - CODE_W){1'b0}}, b_q};
    assign zero_slope = (rd_slope == '0);

    // Rounded numerator for code-to-temperature
    always_comb begin
        num  = code_a * SCALE_X - off_x;
        half = (slope_x < 0) ? -((-slope_x) >>> 1) : (slope_x >>> 1);
        if (num > 0)      num_r = num + half;
        else if (num < 0) num_r = num - half;
        else              num_r = num;
    end

    // Divider operand selection by operation and phase
    always_comb begin
        dvd = '0;
        dvs = SCALE_X;
        case (op_q)
            OP_C2T: begin
                dvd = num_r;
                dvs = slope_x;
            end
            OP_T2C: begin
                if (!phase_q) begin
                    dvd = a_x;
                    dvs = MILLI_X;
                end else begin
                    dvd = deg_q * slope_x + off_x;
                    dvs = SCALE_X;
                end
            end
            OP_CAL2: begin
                dvd = (code_b - code_a) * SCALE_X;
                dvs = SPAN_X;
            end
            default: ;
        endcase
    end

    assign div_start = (state_q == ST_LOAD) && !((op_q == OP_C2T) && zero_slope);

    tc_sdiv #(.W(XW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .dvd   (dvd),
        .dvs   (dvs),
        .quo   (div_q),
        .done  (div_done)
    );

    // Final result and coefficient write values
    always_comb begin
        wr_slope    = (op_q == OP_CAL2) ? DW'(quo_q) : DW'(DEF_SLOPE);
        new_slope_x = wr_slope;
        wr_off      = DW'(code_a * SCALE_X - CALLO_X * new_slope_x);
        rf_we       = (state_q == ST_FIN) && ((op_q == OP_CAL2) || (op_q == OP_CAL1));
        c2t_d       = zs_q ? '0 : DW'(quo_q * MILLI_X);
        if (quo_q < CMIN_X)      t2c_x = CMIN_X;
        else if (quo_q > CMAX_X) t2c_x = CMAX_X;
        else                     t2c_x = quo_q;
        case (op_q)
            OP_C2T:  fin_data = c2t_d;
            OP_T2C:  fin_data = DW'(t2c_x);
            default: fin_data = wr_slope;
        endcase
    end

    tc_coef_rf #(.NSENS(NSENS), .DW(DW), .DEF_SLOPE(DEF_SLOPE)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (rf_we),
        .idx      (idx_q),
        .wr_slope (wr_slope),
        .wr_off   (wr_off),
        .rd_slope (rd_slope),
        .rd_off   (rd_off)
    );

    // Request sequencing state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_q      <= OP_C2T;
            idx_q     <= '0;
            a_q       <= '0;
            b_q       <= '0;
            phase_q   <= 1'b0;
            zs_q      <= 1'b0;
            deg_q     <= '0;
            quo_q     <= '0;
            done      <= 1'b0;
            resp_data <= '0;
            resp_err  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    op_q    <= tc_op_e'(req_op);
                    idx_q   <= req_idx;
                    a_q     <= req_a;
                    b_q     <= req_b[CODE_W-1:0];
                    phase_q <= 1'b0;
                    zs_q    <= 1'b0;
                    state_q <= (tc_op_e'(req_op) == OP_CAL1) ? ST_FIN : ST_LOAD;
                end
                ST_LOAD: begin
                    if ((op_q == OP_C2T) && zero_slope) begin
                        zs_q    <= 1'b1;
                        state_q <= ST_FIN;
                    end else begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: if (div_done) begin
                    if ((op_q == OP_T2C) && !phase_q) begin
                        deg_q   <= div_q;
                        phase_q <= 1'b1;
                        state_q <= ST_LOAD;
                    end else begin
                        quo_q   <= div_q;
                        state_q <= ST_FIN;
                    end
                end
                default: begin
                    resp_data <= fin_data;
                    resp_err  <= zs_q;
                    done      <= 1'b1;
                    state_q   <= ST_IDLE;
                end
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/tc_conv_chk.sv
// Protocol and result-range checker for tc_conv, attached by bind.
// Tracks the operation of the last accepted request on its own.
module tc_conv_chk #(
    parameter int DW       = 32,
    parameter int CODE_MIN = 0,
    parameter int CODE_MAX = 1023
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [1:0]           req_op,
    input logic                 busy,
    input logic                 done,
    input logic signed [DW-1:0] resp_data,
    input logic                 resp_err
);
    logic [1:0] last_op;

    // Capture the operation of each accepted request
    always_ff @(posedge clk) begin
        if (!rst_n)                  last_op <= 2'd0;
        else if (req_valid && !busy) last_op <= req_op;
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R2
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && last_op == 2'd1) |-> (resp_data >= CODE_MIN && resp_data <= CODE_MAX));

    // R8
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && resp_err) |-> (resp_data == 0 && last_op == 2'd0));

    // R5
    milli_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && last_op == 2'd0) |-> (resp_data % 1000 == 0));
endmodule

bind tc_conv tc_conv_chk #(.DW(DW), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX)) u_chk (.*);

// File: tb/sim_tc_conv.sv
// Self-checking bench for tc_conv: a vector table walked in order, then
// directed checks of reset state and handshake corner cases.
module sim_tc_conv;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic [1:0]         req_op = 2'd0;
    logic [1:0]         req_idx = 2'd0;
    logic signed [31:0] req_a = '0;
    logic signed [31:0] req_b = '0;
    logic               busy, done, resp_err;
    logic signed [31:0] resp_data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    tc_conv u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_idx(req_idx), .req_a(req_a), .req_b(req_b), .busy(busy),
        .done(done), .resp_data(resp_data), .resp_err(resp_err)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  idx;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
        logic        eerr;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 2'd0, 32'd500, 32'd860, 32'd12800, 1'b0},     // R3 slope 12800, offset 1216000
        '{2'd0, 2'd0, 32'd500, 32'd0, 32'd30000, 1'b0},       // R5
        '{2'd0, 2'd0, 32'd860, 32'd0, 32'd120000, 1'b0},      // R5
        '{2'd0, 2'd0, 32'd401, 32'd0, 32'd5000, 1'b0},        // R5 5.25 -> 5
        '{2'd0, 2'd0, 32'd381, 32'd0, 32'd0, 1'b0},           // R5 0.25 -> 0
        '{2'd0, 2'd0, 32'd380, 32'd0, 32'd0, 1'b0},           // R5 num zero
        '{2'd0, 2'd0, 32'd300, 32'd0, -32'sd20000, 1'b0},     // R5 negative
        '{2'd0, 2'd0, 32'd382, 32'd0, 32'd1000, 1'b0},        // R5 tie +0.5 -> 1
        '{2'd0, 2'd0, 32'd378, 32'd0, -32'sd1000, 1'b0},      // R5 tie -0.5 -> -1
        '{2'd1, 2'd0, 32'd30000, 32'd0, 32'd500, 1'b0},       // R6
        '{2'd1, 2'd0, 32'd45999, 32'd0, 32'd560, 1'b0},       // R6 truncation
        '{2'd1, 2'd0, -32'sd40000, 32'd0, 32'd220, 1'b0},     // R6
        '{2'd1, 2'd0, -32'sd40999, 32'd0, 32'd220, 1'b0},     // R6 toward zero
        '{2'd1, 2'd0, 32'd200000, 32'd0, 32'd1023, 1'b0},     // R7 upper clamp
        '{2'd1, 2'd0, -32'sd100000, 32'd0, 32'd0, 1'b0},      // R7 lower clamp
        '{2'd0, 2'd1, 32'd100, 32'd0, 32'd100000, 1'b0},      // R1 default coefficients
        '{2'd1, 2'd1, 32'd25000, 32'd0, 32'd25, 1'b0},        // R1 default coefficients
        '{2'd3, 2'd2, 32'd300, 32'd0, 32'd3200, 1'b0},        // R4 offset 864000
        '{2'd0, 2'd2, 32'd300, 32'd0, 32'd30000, 1'b0},       // R4
        '{2'd2, 2'd3, 32'd400, 32'd400, 32'd0, 1'b0},         // R3 zero slope
        '{2'd0, 2'd3, 32'd400, 32'd0, 32'd0, 1'b1},           // R8 error
        '{2'd1, 2'd3, 32'd0, 32'd0, 32'd400, 1'b0},           // R8 error clear
        '{2'd0, 2'd0, 32'd500, 32'd0, 32'd30000, 1'b0}        // R9 sensor 0 untouched
    };

    function automatic string req_of(input logic [1:0] op);
        case (op)
            2'd0:    return "R5";
            2'd1:    return "R6";
            2'd2:    return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Issue one request and wait for done; samples at falling edges
    task automatic run_op(input logic [1:0] op, input logic [1:0] idx,
                          input logic [31:0] a, input logic [31:0] b,
                          output logic signed [31:0] d, output logic e);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_idx = idx; req_a = a; req_b = b;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 2000) check(1'b0, "R2 timeout", 0, 1);
        d = resp_data;
        e = resp_err;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic signed [31:0] d;
        logic e;
        int cnt;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy idle", int'(busy), 0);

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].op, VECS[i].idx, VECS[i].a, VECS[i].b, d, e);
            check(d == $signed(VECS[i].exp), $sformatf("%s vec%0d data", req_of(VECS[i].op), i),
                  int'(d), int'($signed(VECS[i].exp)));
            check(e == VECS[i].eerr, $sformatf("R8 vec%0d err", i), int'(e), int'(VECS[i].eerr));
        end

        // R2 busy rises after acceptance, done is one cycle wide
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_idx = 2'd1; req_a = 32'd100; req_b = '0;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
        // R2 a request raised while busy is ignored
        req_valid = 1'b1; req_op = 2'd1; req_idx = 2'd0; req_a = 32'd30000;
        @(negedge clk);
        req_valid = 1'b0;
        cnt = 0;
        while (!done && cnt < 2000) begin
            @(negedge clk);
            cnt++;
        end
        check(busy == 1'b0, "R2 busy low with done", int'(busy), 0);
        check(resp_data == 32'sd100000, "R2 first request result", int'(resp_data), 100000);
        @(negedge clk);
        check(done == 1'b0, "R2 done single cycle", int'(done), 0);
        cnt = 0;
        for (int k = 0; k < 150; k++) begin
            @(negedge clk);
            if (done) cnt++;
        end
        check(cnt == 0, "R2 ignored request produced no result", cnt, 0);
        check(resp_data == 32'sd100000, "R2 result held", int'(resp_data), 100000);

        // R9 sensor 1 still on defaults after other calibrations
        run_op(2'd1, 2'd1, 32'd25000, 32'd0, d, e);
        check(d == 32'sd25, "R9 sensor1 unchanged", int'(d), 25);

        finish_run();
    end
endmodule